// File: doc/BRIEF.md
# Serial Clock Hold Detector for Converter Sync and Sleep

This block watches the serial clock line of a converter's output port and measures how long the host keeps it high. The measure is taken in conversion periods, not in system clocks. A short hold of a few periods puts the modulator into reset so that several converters can be restarted together. A long hold also places the converter in its sleep state.

When the hold is first recognised, the block takes control of the data-ready pin. It drives the pin low for a short burst, then drives it high, and keeps driving it until the host lets the clock fall again. The falling clock ends the reset or sleep state. It also fires a one-cycle restart strobe so that the filter and the output controller begin a fresh conversion cycle. The block tracks how many data-ready periods have passed since reset or since the last release, and it flags data as trustworthy only from the sixth one on.

The serial clock input must already be synchronised to the system clock. The period tick is a one-cycle pulse, issued once per conversion period.

Top module: `sclk_hold_ctrl`

## Requirements
- R1: The hold counter counts period ticks sampled with the serial clock high. It clears at a tick sampled with the clock low, and at any falling edge of the clock, even one between ticks.
- R2: In the cycle after the 4th consecutive high tick, mod_rst_o is 1, pin_force_o is 1 and data_valid_o is 0.
- R3: On entry, pin_level_o is 0 for exactly 3 system clock cycles. It is then 1, and stays 1 until release.
- R4: In the cycle after the 20th consecutive high tick, pwr_down_o is 1 and mod_rst_o stays 1. Further high ticks leave all outputs unchanged: the counter saturates and no second low pulse appears.
- R5: A falling edge of the serial clock while in reset or sleep does the following in the next cycle. It clears mod_rst_o, pwr_down_o and pin_force_o, and it drives restart_o to 1 for exactly one cycle.
- R6: A falling edge after fewer than 4 high ticks produces no restart_o and no change to mod_rst_o or data_valid_o.
- R7: data_valid_o becomes 1 in the cycle after the 6th period tick following reset or a release. A tick in the same cycle as the releasing falling edge is not counted. The flag is 0 while reset or sleep is active.
- R8: After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| sclk_i | input | 1 | Serial clock level, already synchronised |
| period_tick_i | input | 1 | One-cycle pulse per conversion period |
| mod_rst_o | output | 1 | Holds the modulator in reset |
| pwr_down_o | output | 1 | Sleep state request |
| pin_force_o | output | 1 | Data-ready pin is driven by this block |
| pin_level_o | output | 1 | Level to drive on the pin while forced |
| restart_o | output | 1 | One-cycle restart strobe on release |
| data_valid_o | output | 1 | Output data may be trusted |

## Verification
A release edge and a period tick can fall in the same cycle. The bench provokes this by dropping the clock exactly on a tick when it leaves the sleep state. It then judges that the restart strobe fires and that the coincident tick does not count toward the six-period validity wait: the flag must still be low after five further ticks and high after the sixth. A falling edge that lands between ticks is also driven, to show that it clears the count even though no tick ever saw the clock low.

// File: rtl/sclk_hold_pkg.sv
package sclk_hold_pkg;

    typedef enum logic [1:0] {
        MODE_RUN  = 2'd0,
        MODE_SYNC = 2'd1,
        MODE_PDN  = 2'd2
    } hold_mode_e;

endpackage

// File: rtl/sclk_hold_counter.sv
module sclk_hold_counter #(
    parameter int SYNC_PERIODS = 4,
    parameter int PDN_PERIODS  = 20
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic tick_i,
    output logic fall_o,
    output logic sync_hit_o,
    output logic pdn_hit_o
);
    localparam int CW = $clog2(PDN_PERIODS + 1);
    localparam logic [CW-1:0] SYNC_LAST = CW'(SYNC_PERIODS - 1);
    localparam logic [CW-1:0] PDN_LAST  = CW'(PDN_PERIODS - 1);
    localparam logic [CW-1:0] CNT_MAX   = CW'(PDN_PERIODS);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          sclk_prev;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        st_d           = st_q;
        st_d.sclk_prev = sclk_i;
        fall_o         = st_q.sclk_prev & ~sclk_i;
        sync_hit_o     = tick_i & sclk_i & (st_q.cnt == SYNC_LAST);
        pdn_hit_o      = tick_i & sclk_i & (st_q.cnt == PDN_LAST);
        if (fall_o) begin
            st_d.cnt = '0;
        end else if (tick_i) begin
            if (!sclk_i) begin
                st_d.cnt = '0;
            end else if (st_q.cnt != CNT_MAX) begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // R4
    cnt_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.cnt <= CNT_MAX);

    // R1
    low_tick_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (tick_i && !sclk_i) |=> (st_q.cnt == '0));

endmodule

// File: rtl/sclk_hold_fsm.sv
module sclk_hold_fsm
    import sclk_hold_pkg::*;
#(
    parameter int PULSE_CLKS = 3
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sync_hit_i,
    input  logic pdn_hit_i,
    input  logic fall_i,
    output logic mod_rst_o,
    output logic pwr_down_o,
    output logic pin_force_o,
    output logic pin_level_o,
    output logic restart_o,
    output logic hold_next_o
);
    localparam int PW = $clog2(PULSE_CLKS + 1);

    typedef struct packed {
        hold_mode_e    mode;
        logic [PW-1:0] pulse;
        logic          restart;
    } fsm_state_t;

    fsm_state_t st_d, st_q;

    always_comb begin
        st_d         = st_q;
        st_d.restart = 1'b0;
        if (st_q.pulse != '0) begin
            st_d.pulse = st_q.pulse - 1'b1;
        end
        unique case (st_q.mode)
            MODE_RUN: begin
                if (sync_hit_i) begin
                    st_d.mode  = MODE_SYNC;
                    st_d.pulse = PW'(PULSE_CLKS);
                end
            end
            MODE_SYNC: begin
                if (fall_i) begin
                    st_d.mode    = MODE_RUN;
                    st_d.pulse   = '0;
                    st_d.restart = 1'b1;
                end else if (pdn_hit_i) begin
                    st_d.mode = MODE_PDN;
                end
            end
            MODE_PDN: begin
                if (fall_i) begin
                    st_d.mode    = MODE_RUN;
                    st_d.pulse   = '0;
                    st_d.restart = 1'b1;
                end
            end
            default: begin
                st_d.mode  = MODE_RUN;
                st_d.pulse = '0;
            end
        endcase
        hold_next_o = (st_d.mode != MODE_RUN);
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '{mode: MODE_RUN, pulse: '0, restart: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mod_rst_o   = (st_q.mode != MODE_RUN);
    assign pwr_down_o  = (st_q.mode == MODE_PDN);
    assign pin_force_o = mod_rst_o;
    assign pin_level_o = mod_rst_o & (st_q.pulse == '0);
    assign restart_o   = st_q.restart;

    // R3
    pulse_starts_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(pin_force_o) |-> !pin_level_o);

    // R4
    pdn_implies_rst_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pwr_down_o |-> mod_rst_o);

    // R5
    restart_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_o |=> !restart_o);

    // R3
    level_no_refall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pin_level_o && pin_force_o) |=> (pin_level_o || !pin_force_o));

endmodule

// File: rtl/sclk_valid_tracker.sv
module sclk_valid_tracker #(
    parameter int VALID_PULSES = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic tick_i,
    input  logic hold_now_i,
    input  logic hold_next_i,
    output logic valid_o
);
    localparam int VW = $clog2(VALID_PULSES + 1);
    localparam logic [VW-1:0] V_MAX = VW'(VALID_PULSES);

    typedef struct packed {
        logic [VW-1:0] cnt;
    } val_state_t;

    val_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hold_now_i || hold_next_i) begin
            st_d.cnt = '0;
        end else if (tick_i && (st_q.cnt != V_MAX)) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign valid_o = (st_q.cnt == V_MAX);

    // R7
    valid_needs_tick_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(valid_o) |-> $past(tick_i));

endmodule

// File: rtl/sclk_hold_ctrl.sv
module sclk_hold_ctrl #(
    parameter int SYNC_PERIODS = 4,
    parameter int PDN_PERIODS  = 20,
    parameter int PULSE_CLKS   = 3,
    parameter int VALID_PULSES = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sclk_i,
    input  logic period_tick_i,
    output logic mod_rst_o,
    output logic pwr_down_o,
    output logic pin_force_o,
    output logic pin_level_o,
    output logic restart_o,
    output logic data_valid_o
);
    logic fall, sync_hit, pdn_hit, hold_next;

    sclk_hold_counter #(
        .SYNC_PERIODS(SYNC_PERIODS),
        .PDN_PERIODS (PDN_PERIODS)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .sclk_i    (sclk_i),
        .tick_i    (period_tick_i),
        .fall_o    (fall),
        .sync_hit_o(sync_hit),
        .pdn_hit_o (pdn_hit)
    );

    sclk_hold_fsm #(
        .PULSE_CLKS(PULSE_CLKS)
    ) u_fsm (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sync_hit_i (sync_hit),
        .pdn_hit_i  (pdn_hit),
        .fall_i     (fall),
        .mod_rst_o  (mod_rst_o),
        .pwr_down_o (pwr_down_o),
        .pin_force_o(pin_force_o),
        .pin_level_o(pin_level_o),
        .restart_o  (restart_o),
        .hold_next_o(hold_next)
    );

    sclk_valid_tracker #(
        .VALID_PULSES(VALID_PULSES)
    ) u_val (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .tick_i     (period_tick_i),
        .hold_now_i (mod_rst_o),
        .hold_next_i(hold_next),
        .valid_o    (data_valid_o)
    );

    // R5
    restart_after_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        restart_o |-> (!mod_rst_o && $past(mod_rst_o)));

    // R7
    valid_not_in_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        data_valid_o |-> !mod_rst_o);

    // R6
    early_fall_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fall && !mod_rst_o) |=> !restart_o);

endmodule

// File: tb/sclk_hold_ctrl_tb_top.sv
module sclk_hold_ctrl_tb_top;
    localparam int P = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sclk_r = 1'b0;
    logic tick_r = 1'b0;
    logic mod_rst, pwr_down, pin_force, pin_level, restart, data_valid;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    typedef struct {
        string      tag;
        logic [5:0] exp;
    } item_t;

    item_t sb_q[$];
    event chk_ev;

    always #5 clk = ~clk;

    sclk_hold_ctrl dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .sclk_i       (sclk_r),
        .period_tick_i(tick_r),
        .mod_rst_o    (mod_rst),
        .pwr_down_o   (pwr_down),
        .pin_force_o  (pin_force),
        .pin_level_o  (pin_level),
        .restart_o    (restart),
        .data_valid_o (data_valid)
    );

    // monitor: pops expected items and compares against the ports
    initial begin
        forever begin
            @(chk_ev);
            while (sb_q.size() > 0) begin
                item_t it;
                logic [5:0] act;
                it  = sb_q.pop_front();
                act = {mod_rst, pwr_down, pin_force, pin_level, restart, data_valid};
                total++;
                if (act !== it.exp) begin
                    bad++;
                    $display("FAIL %s got=%b exp=%b", it.tag, act, it.exp);
                end
            end
        end
    end

    // order: mod_rst pwr_down force level restart valid
    task automatic expect_o(input string tag, input logic [5:0] e);
        item_t it;
        it.tag = tag;
        it.exp = e;
        sb_q.push_back(it);
        -> chk_ev;
        #1;
    endtask

    task automatic cyc(input logic s, input logic t);
        sclk_r = s;
        tick_r = t;
        @(negedge clk);
    endtask

    task automatic idle(input logic s, input int n);
        for (int i = 0; i < n; i++) cyc(s, 1'b0);
    endtask

    task automatic period(input logic s);
        cyc(s, 1'b1);
        idle(s, P - 1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=hung exp=finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        expect_o("R8 reset state", 6'b000000);

        // R7: validity after reset needs six ticks
        for (int i = 0; i < 5; i++) period(1'b0);
        expect_o("R7 five ticks after reset", 6'b000000);
        cyc(1'b0, 1'b1);
        expect_o("R7 sixth tick after reset", 6'b000001);
        idle(1'b0, P - 1);

        // R1: low at a tick clears the count
        for (int i = 0; i < 3; i++) period(1'b1);
        cyc(1'b0, 1'b1);
        idle(1'b1, P - 1);
        for (int i = 0; i < 3; i++) period(1'b1);
        expect_o("R1 low tick cleared count", 6'b000001);
        // R6: early fall has no effect
        cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b0);
        expect_o("R6 early fall ignored", 6'b000001);
        idle(1'b0, P - 2);

        // R1: a fall between ticks also clears
        for (int i = 0; i < 3; i++) period(1'b1);
        cyc(1'b0, 1'b0);
        idle(1'b1, P - 2);
        cyc(1'b1, 1'b1);
        expect_o("R1 fall between ticks cleared count", 6'b000001);
        idle(1'b1, P - 1);
        period(1'b1);
        period(1'b1);

        // R2 / R3: fourth high tick
        cyc(1'b1, 1'b1);
        expect_o("R2 sync entry", 6'b101000);
        cyc(1'b1, 1'b0);
        expect_o("R3 pulse low 2", 6'b101000);
        cyc(1'b1, 1'b0);
        expect_o("R3 pulse low 3", 6'b101000);
        cyc(1'b1, 1'b0);
        expect_o("R3 pin high after pulse", 6'b101100);
        idle(1'b1, P - 4);
        period(1'b1);
        expect_o("R3 held high in sync", 6'b101100);

        // R5: release from sync
        cyc(1'b0, 1'b0);
        expect_o("R5 sync release", 6'b000010);
        cyc(1'b0, 1'b0);
        expect_o("R5 restart one cycle", 6'b000000);
        idle(1'b0, P - 2);

        // R7: validity after release
        for (int i = 0; i < 5; i++) period(1'b0);
        expect_o("R7 five ticks after release", 6'b000000);
        cyc(1'b0, 1'b1);
        expect_o("R7 sixth tick after release", 6'b000001);
        idle(1'b0, P - 1);

        // R4: power-down after twenty high ticks
        for (int i = 0; i < 19; i++) period(1'b1);
        expect_o("R4 nineteen ticks not yet sleep", 6'b101100);
        cyc(1'b1, 1'b1);
        expect_o("R4 sleep entry", 6'b111100);
        idle(1'b1, P - 1);
        for (int i = 0; i < 3; i++) period(1'b1);
        expect_o("R4 saturated no re-pulse", 6'b111100);

        // R5 / R7: release coinciding with a tick
        cyc(1'b0, 1'b1);
        expect_o("R5 sleep release on tick", 6'b000010);
        idle(1'b0, P - 1);
        for (int i = 0; i < 5; i++) period(1'b0);
        expect_o("R7 coincident tick not counted", 6'b000000);
        cyc(1'b0, 1'b1);
        expect_o("R7 sixth tick after sleep", 6'b000001);
        idle(1'b0, 2);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule